// File: doc/BRIEF.md
# ASCII Digit String Packer

This block turns a short run of characters from a byte-wide receive path, such as the parallel output of a serial receiver, into one packed hexadecimal word. Each character comes with a single-cycle ready strobe. A character in the range '0' to '9' is reduced to its numeric value before it is kept. Any other byte is kept as it is. Only the low four bits of each kept character take part in the output. The first character received sits in the most significant nibble, so typing "1234" gives 0x1234.

The write position advances by one with each character. It stops at the last slot, so any extra characters keep replacing the least significant nibble. A full flag shows that the string is complete. A synchronous clear starts a new string.

Top module: `digit_packer`

## Requirements
- R1: A byte is captured only on a clock edge where `rx_rdy` is 1 and `clr` is 0. On any other edge `packed_word`, `idx` and `full` keep their values, whatever `rx_byte` holds.
- R2: A byte from 0x30 to 0x39 inclusive is kept as the byte minus 0x30, so its nibble equals the digit value (for example '7' gives 7).
- R3: Any other byte is kept unchanged, and only its bits 3:0 reach the output (for example 0xF1 gives nibble 1 and 0x3A gives nibble A).
- R4: `idx` starts at 0 and rises by one on each capture. It names the slot that the next byte will fill.
- R5: `idx` never exceeds DEPTH-1 and never wraps. Once it is at DEPTH-1, every further captured byte replaces the last slot, which is bits 3:0.
- R6: Slot k occupies `packed_word` bits [4*(DEPTH-1-k)+3 : 4*(DEPTH-1-k)], so "1234" gives 0x1234 at DEPTH 4.
- R7: `full` rises on the edge that captures the DEPTH-th byte since the last clear, and it stays high until a clear or reset.
- R8: When `clr` is 1 at an edge, `idx`, `full` and every nibble of `packed_word` become 0, and a byte strobed in that same cycle is dropped.
- R9: `rst` is synchronous and active high. It leaves the same all-zero state as a clear.
- R10: `packed_word` is a register. A captured byte becomes visible in it right after the edge that captures it, and it stays there until that slot is overwritten or cleared.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| rx_byte | input | 8 | Received character |
| rx_rdy | input | 1 | One-cycle strobe marking `rx_byte` valid |
| clr | input | 1 | Synchronous request to start a new string |
| packed_word | output | 4*DEPTH | Packed nibbles, first character most significant |
| full | output | 1 | DEPTH characters captured since last clear |
| idx | output | IDX_W | Slot that the next character will fill |

## Verification
A clear and a character strobe can land on the same edge, and the clear must win: the character is lost and the string restarts empty. The bench fills the buffer and then raises `clr` and `rx_rdy` together with a digit on `rx_byte`. It then checks that all outputs are zero. It next sends one more character and checks that this character lands in slot 0 and that nothing of the dropped digit remains. A capture into the saturated last slot is a second collision, because the index stays put while the data changes. That case is judged by the least significant nibble changing while `idx` and `full` hold.

// File: rtl/digit_pack_pkg.sv
package digit_pack_pkg;

    localparam int NIB_W = 4;
    localparam int CHAR_W = 8;
    localparam logic [CHAR_W-1:0] CH_ZERO = 8'h30;
    localparam logic [CHAR_W-1:0] CH_NINE = 8'h39;

    // Digits become their value, anything else passes unchanged
    function automatic logic [CHAR_W-1:0] char_to_entry(input logic [CHAR_W-1:0] ch);
        if (ch >= CH_ZERO && ch <= CH_NINE)
            return ch - CH_ZERO;
        return ch;
    endfunction

endpackage

// File: rtl/digit_pack_conv.sv
module digit_pack_conv
    import digit_pack_pkg::*;
(
    input  logic [CHAR_W-1:0] ch_i,
    output logic [NIB_W-1:0]  nib_o
);

    always_comb begin
        nib_o = NIB_W'(char_to_entry(ch_i));
    end

endmodule

// File: rtl/digit_pack_index.sv
module digit_pack_index #(
    parameter int DEPTH = 4,
    parameter int IDX_W = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             store,
    output logic [IDX_W-1:0] idx_o,
    output logic             full_o
);

    localparam logic [IDX_W-1:0] LAST = IDX_W'(DEPTH - 1);

    typedef struct packed {
        logic [IDX_W-1:0] idx;
        logic             full;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    always_comb begin
        ctl_d = ctl_q;
        if (clr) begin
            ctl_d = '0;
        end else if (store) begin
            if (ctl_q.idx == LAST)
                ctl_d.full = 1'b1;
            else
                ctl_d.idx = ctl_q.idx + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst)
            ctl_q <= '0;
        else
            ctl_q <= ctl_d;
    end

    assign idx_o  = ctl_q.idx;
    assign full_o = ctl_q.full;

endmodule

// File: rtl/digit_packer.sv
module digit_packer
    import digit_pack_pkg::*;
#(
    parameter int DEPTH  = 4,
    parameter int PACK_W = 4 * DEPTH,
    parameter int IDX_W  = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [7:0]        rx_byte,
    input  logic              rx_rdy,
    input  logic              clr,
    output logic [PACK_W-1:0] packed_word,
    output logic              full,
    output logic [IDX_W-1:0]  idx
);

    typedef struct packed {
        logic [PACK_W-1:0] word;
    } pk_t;

    pk_t              pk_d, pk_q;
    logic             store;
    logic [NIB_W-1:0] nib;
    logic [DEPTH-1:0] slot_we;

    assign store = rx_rdy & ~clr;

    digit_pack_conv u_conv (
        .ch_i  (rx_byte),
        .nib_o (nib)
    );

    digit_pack_index #(
        .DEPTH (DEPTH),
        .IDX_W (IDX_W)
    ) u_index (
        .clk    (clk),
        .rst    (rst),
        .clr    (clr),
        .store  (store),
        .idx_o  (idx),
        .full_o (full)
    );

    // One write enable per slot, decoded from the current index
    for (genvar g = 0; g < DEPTH; g++) begin : g_slot_we
        assign slot_we[g] = store && (idx == IDX_W'(g));
    end

    always_comb begin
        pk_d = pk_q;
        if (clr) begin
            pk_d = '0;
        end else begin
            for (int k = 0; k < DEPTH; k++) begin
                if (slot_we[k])
                    pk_d.word[NIB_W*(DEPTH-1-k) +: NIB_W] = nib;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst)
            pk_q <= '0;
        else
            pk_q <= pk_d;
    end

    assign packed_word = pk_q.word;

endmodule

// File: rtl/digit_packer_chk.sv
module digit_packer_chk #(
    parameter int DEPTH  = 4,
    parameter int PACK_W = 4 * DEPTH,
    parameter int IDX_W  = 2
) (
    input logic              clk,
    input logic              rst,
    input logic [7:0]        rx_byte,
    input logic              rx_rdy,
    input logic              clr,
    input logic [PACK_W-1:0] packed_word,
    input logic              full,
    input logic [IDX_W-1:0]  idx
);

    localparam logic [IDX_W-1:0] LAST = IDX_W'(DEPTH - 1);

    function automatic logic [3:0] nib_at(input logic [PACK_W-1:0] w, input logic [IDX_W-1:0] k);
        return 4'(w >> (4 * (DEPTH - 1 - int'(k))));
    endfunction

    a_r1_idle_hold: assert property (@(posedge clk) disable iff (rst)
        (!rx_rdy && !clr) |=> ($stable(packed_word) && $stable(idx) && $stable(full)));

    // R2 and R3: the stored nibble is the low nibble of the character
    a_r3_slot_nibble: assert property (@(posedge clk) disable iff (rst)
        (rx_rdy && !clr) |=> (nib_at(packed_word, $past(idx)) == $past(rx_byte[3:0])));

    a_r4_idx_step: assert property (@(posedge clk) disable iff (rst)
        (rx_rdy && !clr && idx != LAST) |=> (idx == IDX_W'($past(idx) + 1'b1)));

    a_r5_idx_saturate: assert property (@(posedge clk) disable iff (rst)
        (rx_rdy && !clr && idx == LAST) |=> (idx == LAST));

    a_r5_idx_range: assert property (@(posedge clk) disable iff (rst)
        idx <= LAST);

    a_r7_full_rise: assert property (@(posedge clk) disable iff (rst)
        (rx_rdy && !clr && idx == LAST) |=> full);

    a_r7_full_sticky: assert property (@(posedge clk) disable iff (rst)
        (full && !clr) |=> full);

    a_r8_clear: assert property (@(posedge clk) disable iff (rst)
        clr |=> (idx == '0 && packed_word == '0 && !full));

endmodule

bind digit_packer digit_packer_chk #(
    .DEPTH  (DEPTH),
    .PACK_W (PACK_W),
    .IDX_W  (IDX_W)
) u_chk (
    .clk         (clk),
    .rst         (rst),
    .rx_byte     (rx_byte),
    .rx_rdy      (rx_rdy),
    .clr         (clr),
    .packed_word (packed_word),
    .full        (full),
    .idx         (idx)
);

// File: tb/digit_packer_bench.sv
`timescale 1ns/1ps
module digit_packer_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [7:0]  rx_byte = 8'h00;
    logic        rx_rdy = 1'b0;
    logic        clr = 1'b0;
    logic [15:0] packed_word;
    logic        full;
    logic [1:0]  idx;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    digit_packer #(.DEPTH(4)) u_digit_packer (
        .clk         (clk),
        .rst         (rst),
        .rx_byte     (rx_byte),
        .rx_rdy      (rx_rdy),
        .clr         (clr),
        .packed_word (packed_word),
        .full        (full),
        .idx         (idx)
    );

    // {four characters, first in bits 31:24} , expected packed word
    localparam logic [47:0] VECS [6] = '{
        {32'h31323334, 16'h1234},   // R2 R6 digits in order
        {32'h0F0E0D0C, 16'hFEDC},   // R3 raw low values
        {32'h10203040, 16'h0000},   // R3 high nibbles dropped, R2 '0'
        {32'hF1A20D45, 16'h12D5},   // R3 mixed bytes
        {32'h39383730, 16'h9870},   // R2 upper digits
        {32'h3A2F3041, 16'hAF01}    // R2 R3 digit bounds
    };

    task automatic check(input string req, input logic [15:0] ep, input logic ef, input logic [1:0] ei);
        checks++;
        if (packed_word !== ep || full !== ef || idx !== ei) begin
            errors++;
            $display("FAIL %s: packed=%h full=%b idx=%0d expected packed=%h full=%b idx=%0d",
                     req, packed_word, full, idx, ep, ef, ei);
        end
    endtask

    task automatic send(input logic [7:0] b);
        @(negedge clk);
        rx_byte = b;
        rx_rdy  = 1'b1;
        @(negedge clk);
        rx_rdy  = 1'b0;
    endtask

    task automatic do_clear();
        @(negedge clk);
        clr = 1'b1;
        @(negedge clk);
        clr = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R9 reset state", 16'h0000, 1'b0, 2'd0);

        // Table walk
        for (int v = 0; v < 6; v++) begin
            do_clear();
            check("R8 clear before vector", 16'h0000, 1'b0, 2'd0);
            for (int c = 0; c < 4; c++) begin
                send(VECS[v][47 - 8*c -: 8]);
            end
            check("R2 R3 R6 R7 vector", VECS[v][15:0], 1'b1, 2'd3);
        end

        // Partial string: index advances, full stays low
        do_clear();
        send(8'h35);
        check("R4 R10 first char visible", 16'h5000, 1'b0, 2'd1);
        send(8'h36);
        check("R4 R7 partial", 16'h5600, 1'b0, 2'd2);

        // Overflow past DEPTH replaces last slot
        do_clear();
        send(8'h31); send(8'h32); send(8'h33); send(8'h34);
        send(8'h37);
        check("R5 overflow 1", 16'h1237, 1'b1, 2'd3);
        send(8'hF8);
        check("R5 overflow 2", 16'h1238, 1'b1, 2'd3);

        // Clear and strobe together: clear wins, byte dropped
        @(negedge clk);
        clr = 1'b1; rx_rdy = 1'b1; rx_byte = 8'h39;
        @(negedge clk);
        clr = 1'b0; rx_rdy = 1'b0;
        check("R8 clear beats strobe", 16'h0000, 1'b0, 2'd0);
        send(8'h37);
        check("R8 after collision", 16'h7000, 1'b0, 2'd1);

        // Idle: data changes without strobe
        @(negedge clk);
        rx_byte = 8'h35;
        repeat (3) @(negedge clk);
        rx_byte = 8'h42;
        @(negedge clk);
        check("R1 no strobe ignored", 16'h7000, 1'b0, 2'd1);

        // Reset mid string
        send(8'h38);
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        check("R9 reset mid string", 16'h0000, 1'b0, 2'd0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule